// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Wake-up

This block receives asynchronous serial frames and places each byte in a holding register. Every frame has one low start bit, then the data bits least significant first, then one stop bit. When multiprocessor mode is on, one extra bit before the stop bit marks the frame as an address (1) or as data (0). The line is oversampled by a tick that pulses at sixteen times the bit rate. Each bit is read near its centre.

A wake-up control lets a node on a shared line sleep through traffic meant for other nodes. While wake-up is armed in multiprocessor mode, data frames are dropped without trace. The first address frame clears the wake-up control by itself and is handled as a normal reception. Software then reads the address and decides whether to stay awake.

Status flags for data-full, framing error and overrun stay set until their own clear strobes. They drive a receive interrupt request and an error interrupt request, both gated by one enable.

Top module: `mprx_receiver`

## Requirements
- R1: After reset, rx_data is 0, and rx_mpb, rx_full, rx_ferr, rx_ovr, wake_en, rx_irq and err_irq are all 0.
- R2: While rx_en is 0, no frame starts, and a frame sent on the line changes no output. Taking rx_en low leaves rx_full, rx_ferr and rx_ovr unchanged.
- R3: A start is seen when the synchronised line is low on a tick. If the line is high again on the eighth tick after that, the start is dropped as a glitch and no frame is produced.
- R4: A frame is a low start bit, 8 data bits LSB first, an address bit only when mp_mode is 1, and a high stop bit. If rx_full is 0, a good frame loads rx_data and sets rx_full.
- R5: A frame whose stop bit is low, arriving while rx_full is 0, sets rx_ferr. It does not load rx_data and leaves rx_full at 0.
- R6: A frame that completes while rx_full is 1 sets rx_ovr and leaves rx_data unchanged. This check comes before the stop-bit check.
- R7: With mp_mode 1 and wake_en 1, a frame whose address bit is 0 changes nothing: rx_data, rx_mpb, all three flags and wake_en stay as they were, even when its stop bit is low.
- R8: With mp_mode 1 and wake_en 1, a frame whose address bit is 1 clears wake_en, sets rx_mpb to 1 and is then handled as in R4 to R6. Later data frames are accepted normally, with rx_mpb set to 0.
- R9: With mp_mode 0, wake_en has no effect. Frames are accepted normally, wake_en keeps its value and rx_mpb is written 0.
- R10: A one-cycle wake_set pulse sets wake_en to 1.
- R11: clr_full, clr_ferr and clr_ovr each clear only their own flag. When a flag is set and cleared in the same cycle, the set wins.
- R12: rx_irq equals rx_full AND irq_en. err_irq equals (rx_ferr OR rx_ovr) AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idles high |
| tick16 | input | 1 | Oversampling pulse at 16x the bit rate |
| rx_en | input | 1 | Allows new frames to start |
| mp_mode | input | 1 | Adds the address bit to each frame |
| wake_set | input | 1 | Pulse that arms wake-up |
| irq_en | input | 1 | Enable for both interrupt requests |
| clr_full | input | 1 | Pulse that clears rx_full |
| clr_ferr | input | 1 | Pulse that clears rx_ferr |
| clr_ovr | input | 1 | Pulse that clears rx_ovr |
| rx_data | output | 8 | Holding register for the last accepted byte |
| rx_mpb | output | 1 | Address bit of the last accepted frame |
| rx_full | output | 1 | Data-full flag |
| rx_ferr | output | 1 | Framing-error flag |
| rx_ovr | output | 1 | Overrun flag |
| wake_en | output | 1 | Wake-up armed |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
A frame result is due after the stop bit has been sampled. That takes two synchroniser cycles, up to one tick to detect the start, eight ticks to the start midpoint and sixteen ticks per later bit. After that, one register cycle produces the frame-done pulse and one more updates the flags. The driver holds the line idle for two bit times after each stop bit before the monitor samples, so every result has settled well before the sample point. A strobe or wake-up pulse takes effect at the next edge, and the monitor samples on a falling edge after that edge.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    OUT_NONE,
    OUT_LOAD,
    OUT_FERR,
    OUT_OVR
  } rx_outcome_e;

  // tick count (from start detection) at which the start bit is re-checked
  function automatic int unsigned mid_tick(int unsigned ovs);
    return ovs / 2 - 1;
  endfunction

  // bits between start and stop: data plus the optional address bit
  function automatic int unsigned payload_bits(int unsigned dw, logic mp);
    return dw + (mp ? 1 : 0);
  endfunction

  // a frame is dropped only when wake-up is armed in multiprocessor mode
  // and the frame is not an address frame
  function automatic logic wake_drops(logic armed, logic mp, logic addr_bit);
    return armed & mp & ~addr_bit;
  endfunction

  // overrun is checked first, then the stop bit
  function automatic rx_outcome_e judge(logic accepted, logic full_now, logic stop_ok);
    if (!accepted)     return OUT_NONE;
    else if (full_now) return OUT_OVR;
    else if (!stop_ok) return OUT_FERR;
    else               return OUT_LOAD;
  endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mprx_framer.sv
module mprx_framer
  import mprx_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              rx_en,
  input  logic              mp_mode,
  output logic              busy,
  output logic              glitch,
  output logic              done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_mpb,
  output logic              frame_stop
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned BW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] MID  = CW'(mid_tick(OVS));
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] DW_B = BW'(DATA_W);

  rx_state_e         state;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              mpb_r;
  logic              mp_lat;
  logic              done_q, glitch_q, stop_q;
  logic [BW-1:0]     last_idx;

  assign last_idx = BW'(payload_bits(DATA_W, mp_lat) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      mpb_r    <= 1'b0;
      mp_lat   <= 1'b0;
      done_q   <= 1'b0;
      glitch_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      glitch_q <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && rx_en && !rxd_s) begin
            state  <= RX_START;
            tcnt   <= '0;
            mp_lat <= mp_mode;
            mpb_r  <= 1'b0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt == MID) begin
              tcnt <= '0;
              if (rxd_s) begin
                state    <= RX_IDLE;
                glitch_q <= 1'b1;
              end else begin
                state <= RX_BITS;
                bidx  <= '0;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (tcnt == LAST) begin
              tcnt <= '0;
              if (bidx < DW_B) shreg <= {rxd_s, shreg[DATA_W-1:1]};
              else             mpb_r <= rxd_s;
              if (bidx == last_idx) state <= RX_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (tcnt == LAST) begin
              tcnt   <= '0;
              done_q <= 1'b1;
              stop_q <= rxd_s;
              state  <= RX_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy       = (state != RX_IDLE);
  assign glitch     = glitch_q;
  assign done       = done_q;
  assign frame_data = shreg;
  assign frame_mpb  = mpb_r;
  assign frame_stop = stop_q;
endmodule

// File: rtl/mprx_status.sv
module mprx_status
  import mprx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_mpb,
  input  logic              frame_stop,
  input  logic              mp_mode,
  input  logic              wake_set,
  input  logic              irq_en,
  input  logic              clr_full,
  input  logic              clr_ferr,
  input  logic              clr_ovr,
  output logic              accept,
  output logic              discard,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_full,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              wake_en,
  output logic              rx_irq,
  output logic              err_irq
);
  rx_outcome_e outcome;
  logic        wake_clear;

  assign discard    = done & wake_drops(wake_en, mp_mode, frame_mpb);
  assign accept     = done & ~discard;
  assign outcome    = judge(accept, rx_full, frame_stop);
  assign wake_clear = accept & wake_en & mp_mode & frame_mpb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_mpb  <= 1'b0;
      rx_full <= 1'b0;
      rx_ferr <= 1'b0;
      rx_ovr  <= 1'b0;
      wake_en <= 1'b0;
    end else begin
      if (outcome == OUT_LOAD) begin
        rx_data <= frame_data;
        rx_full <= 1'b1;
      end else if (clr_full) begin
        rx_full <= 1'b0;
      end

      if (outcome == OUT_FERR) rx_ferr <= 1'b1;
      else if (clr_ferr)       rx_ferr <= 1'b0;

      if (outcome == OUT_OVR)  rx_ovr <= 1'b1;
      else if (clr_ovr)        rx_ovr <= 1'b0;

      if (accept) rx_mpb <= mp_mode & frame_mpb;

      if (wake_set)        wake_en <= 1'b1;
      else if (wake_clear) wake_en <= 1'b0;
    end
  end

  assign rx_irq  = rx_full & irq_en;
  assign err_irq = (rx_ferr | rx_ovr) & irq_en;
endmodule

// File: rtl/mprx_receiver.sv
module mprx_receiver #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              mp_mode,
  input  logic              wake_set,
  input  logic              irq_en,
  input  logic              clr_full,
  input  logic              clr_ferr,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_full,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              wake_en,
  output logic              rx_irq,
  output logic              err_irq
);
  logic              rxd_s;
  logic              frm_busy, frm_glitch, frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_mpb, frm_stop;
  logic              st_accept, st_discard;

  mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  mprx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s),
    .rx_en(rx_en), .mp_mode(mp_mode),
    .busy(frm_busy), .glitch(frm_glitch), .done(frm_done),
    .frame_data(frm_data), .frame_mpb(frm_mpb), .frame_stop(frm_stop)
  );

  mprx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done(frm_done),
    .frame_data(frm_data), .frame_mpb(frm_mpb), .frame_stop(frm_stop),
    .mp_mode(mp_mode), .wake_set(wake_set), .irq_en(irq_en),
    .clr_full(clr_full), .clr_ferr(clr_ferr), .clr_ovr(clr_ovr),
    .accept(st_accept), .discard(st_discard),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_full(rx_full),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .wake_en(wake_en),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );
endmodule

// File: rtl/mprx_checker.sv
module mprx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              busy,
  input logic              glitch,
  input logic              accept,
  input logic              discard,
  input logic              frame_mpb,
  input logic              frame_stop,
  input logic              mp_mode,
  input logic              wake_set,
  input logic              wake_en,
  input logic              full,
  input logic              ferr,
  input logic              ovr,
  input logic              clr_full,
  input logic              clr_ferr,
  input logic              clr_ovr,
  input logic [DATA_W-1:0] rx_data
);
  a_r2_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy);

  a_r3_glitch_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> !busy);

  a_r5_stop_low_sets_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !full && !frame_stop) |=> (ferr && $stable(rx_data)));

  a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full) |=> (ovr && $stable(rx_data)));

  a_r7_discard_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !clr_full && !clr_ferr && !clr_ovr) |=>
      ($stable(full) && $stable(ferr) && $stable(ovr) && $stable(rx_data) && wake_en));

  a_r8_wake_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frame_mpb && mp_mode && wake_en && !wake_set) |=> !wake_en);

  a_r10_wake_set: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> wake_en);

  a_r11_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_full) |=> full);

  a_r11_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !clr_ferr) |=> ferr);

  a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_ovr) |=> ovr);
endmodule

bind mprx_receiver mprx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .busy(frm_busy),
  .glitch(frm_glitch), .accept(st_accept), .discard(st_discard),
  .frame_mpb(frm_mpb), .frame_stop(frm_stop), .mp_mode(mp_mode),
  .wake_set(wake_set), .wake_en(wake_en), .full(rx_full),
  .ferr(rx_ferr), .ovr(rx_ovr), .clr_full(clr_full),
  .clr_ferr(clr_ferr), .clr_ovr(clr_ovr), .rx_data(rx_data)
);

// File: tb/mprx_receiver_test.sv
`timescale 1ns/1ps
module mprx_receiver_test;
  localparam int BIT_CLK = 32;   // tick every 2 clocks, 16 ticks per bit

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b0;
  logic rx_en = 1'b0, mp_mode = 1'b0, wake_set = 1'b0, irq_en = 1'b0;
  logic clr_full = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rx_data;
  logic rx_mpb, rx_full, rx_ferr, rx_ovr, wake_en, rx_irq, err_irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // bench's own model of the visible state
  logic [7:0] m_data = '0;
  logic m_mpb = 0, m_full = 0, m_ferr = 0, m_ovr = 0, m_wake = 0;

  logic [14:0] exp_q[$];
  string       req_q[$];
  event        chk_ev;

  mprx_receiver uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .rx_en(rx_en),
    .mp_mode(mp_mode), .wake_set(wake_set), .irq_en(irq_en),
    .clr_full(clr_full), .clr_ferr(clr_ferr), .clr_ovr(clr_ovr),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_full(rx_full), .rx_ferr(rx_ferr),
    .rx_ovr(rx_ovr), .wake_en(wake_en), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver side: push the model's expectation and hand it to the monitor
  task automatic expect_now(string req);
    logic ri, ei;
    ri = m_full && irq_en;
    ei = (m_ferr || m_ovr) && irq_en;
    exp_q.push_back({m_wake, ei, ri, m_ovr, m_ferr, m_full, m_mpb, m_data});
    req_q.push_back(req);
    -> chk_ev;
    repeat (3) @(negedge clk);
  endtask

  task automatic hold_bits(int n);
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic mpb, logic stop_ok, string req);
    logic active;
    @(negedge clk);
    rxd = 1'b0; hold_bits(1);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold_bits(1); end
    if (mp_mode) begin rxd = mpb; hold_bits(1); end
    if (stop_ok) begin
      rxd = 1'b1; hold_bits(1);
    end else begin
      rxd = 1'b0; repeat (24) @(negedge clk);
      rxd = 1'b1; repeat (BIT_CLK - 24) @(negedge clk);
    end
    hold_bits(2);
    // expected outcome
    if (rx_en) begin
      active = m_wake && mp_mode;
      if (!(active && !mpb)) begin
        m_mpb = mp_mode ? mpb : 1'b0;
        if (active && mpb) m_wake = 1'b0;
        if (m_full)        m_ovr  = 1'b1;
        else if (!stop_ok) m_ferr = 1'b1;
        else begin m_data = d; m_full = 1'b1; end
      end
    end
    expect_now(req);
  endtask

  task automatic pulse_clr(logic f, logic e, logic o);
    @(negedge clk);
    clr_full = f; clr_ferr = e; clr_ovr = o;
    @(negedge clk);
    clr_full = 1'b0; clr_ferr = 1'b0; clr_ovr = 1'b0;
    if (f) m_full = 1'b0;
    if (e) m_ferr = 1'b0;
    if (o) m_ovr  = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_set = 1'b1;
    @(negedge clk); wake_set = 1'b0;
    m_wake = 1'b1;
  endtask

  // monitor: pops an expectation and compares it with the ports
  initial begin
    forever begin
      logic [14:0] e;
      string r;
      @(chk_ev);
      @(negedge clk);
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, "rx_data", rx_data, e[7:0]);
      check(r, "rx_mpb",  {7'd0, rx_mpb},  {7'd0, e[8]});
      check(r, "rx_full", {7'd0, rx_full}, {7'd0, e[9]});
      check(r, "rx_ferr", {7'd0, rx_ferr}, {7'd0, e[10]});
      check(r, "rx_ovr",  {7'd0, rx_ovr},  {7'd0, e[11]});
      check(r, "rx_irq R12",  {7'd0, rx_irq},  {7'd0, e[12]});
      check(r, "err_irq R12", {7'd0, err_irq}, {7'd0, e[13]});
      check(r, "wake_en", {7'd0, wake_en}, {7'd0, e[14]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R1");                              // reset state

    rx_en = 1'b1;
    send_frame(8'hA5, 1'b0, 1'b1, "R4");           // plain load, irq off
    irq_en = 1'b1;
    expect_now("R12");                             // rx_irq follows enable
    send_frame(8'h3C, 1'b0, 1'b1, "R6");           // overrun, data kept
    pulse_clr(1'b0, 1'b0, 1'b1);
    expect_now("R11");                             // only overrun cleared
    pulse_clr(1'b1, 1'b0, 1'b0);
    expect_now("R11");
    send_frame(8'h5A, 1'b0, 1'b0, "R5");           // low stop bit

    rx_en = 1'b0;
    expect_now("R2");                              // flags kept
    send_frame(8'hFF, 1'b0, 1'b1, "R2");           // ignored while off
    rx_en = 1'b1;
    pulse_clr(1'b0, 1'b1, 1'b0);

    @(negedge clk); rxd = 1'b0;                    // short low pulse
    repeat (6) @(negedge clk); rxd = 1'b1;
    hold_bits(2);
    expect_now("R3");
    send_frame(8'h81, 1'b0, 1'b1, "R4");           // works after a glitch
    pulse_clr(1'b1, 1'b0, 1'b0);

    mp_mode = 1'b1;
    pulse_wake();
    expect_now("R10");
    send_frame(8'h11, 1'b0, 1'b1, "R7");           // data frame dropped
    send_frame(8'h22, 1'b0, 1'b0, "R7");           // dropped, no framing error
    send_frame(8'h47, 1'b1, 1'b1, "R8");           // address wakes the node
    pulse_clr(1'b1, 1'b0, 1'b0);
    send_frame(8'h99, 1'b0, 1'b1, "R8");           // data accepted once awake
    pulse_clr(1'b1, 1'b0, 1'b0);
    send_frame(8'hC3, 1'b1, 1'b0, "R8");           // address frame, bad stop

    pulse_clr(1'b0, 1'b1, 1'b0);
    mp_mode = 1'b0;
    pulse_wake();
    send_frame(8'h6E, 1'b0, 1'b1, "R9");           // wake ignored, mpb 0

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule